// File: doc/BRIEF.md
# Duty-Cycled Temperature Conversion Sequencer

This block decides when the analog temperature converter of a low-power sensor runs. In normal operation a fixed period is counted in clock cycles. At the start of each period the block pulses a start request and raises the converter enable for a short active window, about one tenth of the period. The converter is then idle until the next period begins. When the converter signals that it is done, the block latches the converter's 11-bit two's complement result into the readable temperature register. At the same time it gives a one-cycle end-of-conversion pulse and closes the window early.

A configuration input selects shutdown. While it is high no conversion runs, and a conversion in progress is dropped without touching the register. The register keeps the last good result and can still be read at any time. A conversion begins as soon as reset ends and as soon as shutdown is released. Host reads are passive and never disturb the sequencing.

Top module: `conv_sequencer`

## Requirements
- R1: On the first clock edge at which reset is low and shutdown is low, adc_start_o and adc_en_o both become 1.
- R2: adc_start_o is a one-cycle pulse, and in normal mode successive pulses are exactly PERIOD_CYC cycles apart, whether or not the conversion ended early.
- R3: With no done strobe, adc_en_o stays high for exactly ACTIVE_CYC cycles, starting with the start-pulse cycle, and then stays low until the next start pulse.
- R4: A done strobe sampled while adc_en_o is high loads adc_data_i into temp_o on that edge and drops adc_en_o on the same edge. This includes a strobe in the last cycle of the window.
- R5: eoc_o is high for exactly one cycle for each accepted conversion, in the same cycle in which temp_o shows the new value.
- R6: temp_o holds 11-bit two's complement data at 0.125 °C per LSB (for example 11'h738 is -25.0 °C). It changes only together with eoc_o. A done strobe while adc_en_o is low, and a window that runs out, leave it unchanged.
- R7: While shutdown_i is high, adc_start_o and adc_en_o are 0 from the edge after it is sampled high, no conversion starts, done strobes are ignored, and temp_o is held.
- R8: A shutdown request that arrives during a conversion aborts it. A done strobe sampled in the same cycle as the request, or any later one before the next start, produces no eoc_o and no change of temp_o.
- R9: When shutdown_i is sampled low after shutdown, the next edge produces a start pulse with adc_en_o high.
- R10: rd_strobe_i has no effect: adc_en_o, the period timing and temp_o behave the same with it high or low.
- R11: While reset is high, all outputs are 0 and temp_o is 11'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shutdown_i | input | 1 | Configuration bit: 1 selects shutdown |
| adc_done_i | input | 1 | Converter done strobe |
| adc_data_i | input | DATA_W (11) | Converter result, two's complement |
| rd_strobe_i | input | 1 | Host read of the temperature register |
| adc_start_o | output | 1 | One-cycle conversion start request |
| adc_en_o | output | 1 | Converter enable for the active window |
| temp_o | output | DATA_W (11) | Temperature register |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The hardest cases to reach are those where a done strobe falls on an exact cycle of the window. One is a strobe on the last enabled cycle. Another is a strobe in the same cycle as a shutdown request. Only cycle-exact timing can tell these two apart from an ordinary early finish. The stimulus locks onto each start pulse and counts cycles from it, so it can drive the done strobe on window cycle ACTIVE_CYC-1, or drive it together with shutdown two cycles into a conversion. A scoreboard receives the expected results only for strobes that the requirements say are accepted, so any stray end-of-conversion pulse is reported.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_REST = 2'd2
  } seq_state_e;
endpackage

// File: rtl/cs_period_timer.sv
module cs_period_timer #(
  parameter int PERIOD_CYC = 1000,
  parameter int ACTIVE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic win_last_o,
  output logic period_last_o
);
  localparam int CNT_W = $clog2(PERIOD_CYC);
  localparam logic [CNT_W-1:0] LAST_P = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(ACTIVE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  initial begin
    assert (ACTIVE_CYC > 0 && ACTIVE_CYC < PERIOD_CYC && PERIOD_CYC > 1)
      else $error("cs_period_timer: need 0 < ACTIVE_CYC < PERIOD_CYC");
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST_P) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign win_last_o    = (cnt_q == LAST_W);
  assign period_last_o = (cnt_q == LAST_P);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cnt_q} < (CNT_W + 1)'(PERIOD_CYC)));  // R2
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (cnt_q == '0));  // R7
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import conv_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic shutdown_i,
  input  logic done_i,
  input  logic win_last_i,
  input  logic period_last_i,
  output logic start_o,
  output logic en_o,
  output logic hold_o,
  output logic accept_o
);
  seq_state_e state_q;

  // The timer is held while off or while shutdown is requested.
  assign hold_o   = (state_q == SEQ_OFF) || shutdown_i;
  assign accept_o = (state_q == SEQ_CONV) && done_i && !shutdown_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_OFF;
      start_o <= 1'b0;
      en_o    <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (shutdown_i) begin
        state_q <= SEQ_OFF;
        en_o    <= 1'b0;
      end else begin
        unique case (state_q)
          SEQ_OFF: begin
            state_q <= SEQ_CONV;
            start_o <= 1'b1;
            en_o    <= 1'b1;
          end
          SEQ_CONV: begin
            if (done_i || win_last_i) begin
              state_q <= SEQ_REST;
              en_o    <= 1'b0;
            end
          end
          SEQ_REST: begin
            if (period_last_i) begin
              state_q <= SEQ_CONV;
              start_o <= 1'b1;
              en_o    <= 1'b1;
            end
          end
          default: begin
            state_q <= SEQ_OFF;
            en_o    <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);  // R2
  AST_START_OPENS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    start_o |-> en_o);  // R3
  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !en_o);  // R4
  AST_SHUTDOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    shutdown_i |=> (!en_o && !start_o));  // R7
  AST_WAKE_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_OFF && !shutdown_i) |=> (start_o && en_o));  // R9
endmodule

// File: rtl/cs_result_reg.sv
module cs_result_reg #(
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] temp_o,
  output logic              eoc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      temp_o <= '0;
      eoc_o  <= 1'b0;
    end else begin
      eoc_o <= load_i;
      if (load_i) begin
        temp_o <= data_i;
      end
    end
  end

  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o);  // R5
  AST_TEMP_ONLY_ON_EOC: assert property (@(posedge clk) disable iff (rst)
    !eoc_o |-> $stable(temp_o));  // R6
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int PERIOD_CYC = 1000,
  parameter int ACTIVE_CYC = 100,
  parameter int DATA_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shutdown_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  input  logic              rd_strobe_i,
  output logic              adc_start_o,
  output logic              adc_en_o,
  output logic [DATA_W-1:0] temp_o,
  output logic              eoc_o
);
  logic hold;
  logic win_last;
  logic period_last;
  logic accept;

  cs_period_timer #(
    .PERIOD_CYC(PERIOD_CYC),
    .ACTIVE_CYC(ACTIVE_CYC)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .hold_i       (hold),
    .win_last_o   (win_last),
    .period_last_o(period_last)
  );

  cs_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .shutdown_i   (shutdown_i),
    .done_i       (adc_done_i),
    .win_last_i   (win_last),
    .period_last_i(period_last),
    .start_o      (adc_start_o),
    .en_o         (adc_en_o),
    .hold_o       (hold),
    .accept_o     (accept)
  );

  cs_result_reg #(
    .DATA_W(DATA_W)
  ) u_result (
    .clk   (clk),
    .rst   (rst),
    .load_i(accept),
    .data_i(adc_data_i),
    .temp_o(temp_o),
    .eoc_o (eoc_o)
  );

  // Host reads are passive: they only observe temp_o.
  AST_READ_PASSIVE: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && !adc_en_o) |=> $stable(temp_o));  // R10
  AST_SHUTDOWN_ABORTS: assert property (@(posedge clk) disable iff (rst)
    shutdown_i |=> !eoc_o);  // R8
  AST_DONE_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (adc_done_i && !adc_en_o) |=> !eoc_o);  // R6
endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
  localparam int PER = 40;
  localparam int ACT = 8;
  localparam int DW  = 11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1;
  logic          shutdown = 1'b0;
  logic          done = 1'b0;
  logic          rd = 1'b0;
  logic [DW-1:0] data = '0;
  logic          start, en, eoc;
  logic [DW-1:0] temp;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [DW-1:0] exp_q[$];
  bit   eoc_prev = 1'b0;

  conv_sequencer #(.PERIOD_CYC(PER), .ACTIVE_CYC(ACT), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .shutdown_i(shutdown), .adc_done_i(done),
    .adc_data_i(data), .rd_strobe_i(rd), .adc_start_o(start),
    .adc_en_o(en), .temp_o(temp), .eoc_o(eoc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_done(input logic [DW-1:0] d, input bit taken);
    data = d;
    done = 1'b1;
    if (taken) exp_q.push_back(d);
    step();
    done = 1'b0;
  endtask

  task automatic wait_start(output int waited);
    waited = 0;
    while (!start && waited < 3 * PER) begin
      step();
      waited++;
    end
  endtask

  // Scoreboard monitor: every end-of-conversion pulse must match a queued result.
  always @(negedge clk) begin
    if (!rst) begin
      if (eoc && eoc_prev) check(1'b0, "R5 eoc longer than one cycle", 2, 1);
      if (eoc) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 R8 unexpected eoc", int'(temp), -1);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(temp == e, "R4 R5 temp at eoc", int'(temp), int'(e));
        end
      end
      eoc_prev = eoc;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t0, t1, hi, w, starts;
    step(3);
    check(!start && !en && !eoc, "R11 outputs low in reset", {start, en, eoc}, 0);
    check(temp == '0, "R11 temp in reset", int'(temp), 0);

    rst = 1'b0;
    step();
    check(start && en, "R1 start after reset", {start, en}, 3);
    t0 = cyc;
    step();
    check(!start, "R2 start one cycle", start, 0);

    // Window runs out with no done strobe.
    hi = 1;
    for (int k = 1; k < PER; k++) begin
      if (en) hi++;
      if (start) check(1'b0, "R2 early start", k, PER);
      step();
    end
    check(hi == ACT, "R3 enable window length", hi, ACT);
    check(start == 1'b1, "R2 next start", start, 1);
    check(cyc - t0 == PER, "R2 period spacing", cyc - t0, PER);
    check(temp == '0, "R6 timeout keeps temp", int'(temp), 0);
    t1 = cyc;

    // Early done: -25.0 C.
    step(3);
    drive_done(11'h738, 1'b1);
    check(!en, "R4 enable drops on done", en, 0);
    check(temp == 11'h738, "R4 temp loaded", int'(temp), 'h738);
    step();
    check(!eoc, "R5 eoc cleared", eoc, 0);

    // Done outside the window is ignored.
    drive_done(11'h155, 1'b0);
    check(temp == 11'h738, "R6 done while idle ignored", int'(temp), 'h738);

    wait_start(w);
    check(cyc - t1 == PER, "R2 spacing after early done", cyc - t1, PER);

    // Reads during a conversion; done on the last window cycle.
    rd = 1'b1;
    step(ACT - 1);
    check(en, "R10 enable unaffected by read", en, 1);
    drive_done(11'h3F8, 1'b1);
    check(temp == 11'h3F8 && !en, "R4 done on last window cycle", int'(temp), 'h3F8);
    step(5);
    check(temp == 11'h3F8 && !en, "R10 read while idle", int'(temp), 'h3F8);
    rd = 1'b0;

    // Shutdown mid-conversion with a simultaneous done.
    wait_start(w);
    step(2);
    shutdown = 1'b1;
    drive_done(11'h100, 1'b0);
    check(!en && !start, "R8 abort drops enable", {start, en}, 0);
    check(temp == 11'h3F8, "R8 aborted result discarded", int'(temp), 'h3F8);

    starts = 0;
    hi = 0;
    for (int k = 0; k < 3 * PER; k++) begin
      done = (k == 10);
      data = 11'h0AA;
      step();
      if (start) starts++;
      if (en) hi++;
    end
    done = 1'b0;
    check(starts == 0, "R7 no starts in shutdown", starts, 0);
    check(hi == 0, "R7 enable low in shutdown", hi, 0);
    check(temp == 11'h3F8, "R7 temp held in shutdown", int'(temp), 'h3F8);

    shutdown = 1'b0;
    step();
    check(start && en, "R9 start on wake", {start, en}, 3);
    step(2);
    drive_done(11'h001, 1'b1);
    check(temp == 11'h001, "R9 conversion after wake", int'(temp), 1);

    step(3);
    check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule